// File: doc/BRIEF.md
# Indexed Register Access Controller

This block is the host-facing register port of a display controller. The host presents a 3-bit register select, a write strobe, a read strobe and an 8-bit data bus. A few selects reach registers directly: a pixel mask, the low and high bytes of an 11-bit index pointer, and an index control register. One select is a data window into a larger indexed space. The pointer chooses the location in that space, and the access can step the pointer forward.

The indexed space has two parts. Addresses below 0x100 are a small file of control registers. Addresses 0x100 to 0x7FF are the cursor pattern memory. The pointer steps only when the control register enables it. The pointer stops at the last control address and at the top of the space. The cursor memory can be reached only while the pixel clock runs; otherwise the access is stretched with a ready handshake. Palette address writes raise a restart pulse when a palette sequence is in progress; accesses to the index selects never raise it.

Top module: `host_index_port`

## Requirements
- R1: After reset the pixel mask reads 0xFF, the pointer bytes read 0x00, the index control register reads 0x00, `rdata` is 0x00 and `pal_restart` is low.
- R2: Select 3'b010 is the pixel mask: a write stores all 8 bits and a read returns them, at any time.
- R3: Select 3'b100 is the pointer's bits [7:0] and select 3'b101 is its bits [10:8]. A write to 3'b101 keeps only data bits [2:0], and a read of it returns zero in bits [7:3].
- R4: Select 3'b111 is the index control register. Bit 0 enables auto-increment; the other bits read as zero.
- R5: Select 3'b110 reads or writes the indexed location at the pointer. Control addresses 0x000 to 0x00F hold data. Other addresses below 0x100 read 0x00 and ignore writes.
- R6: After each accepted data-port access the pointer rises by one when bit 0 of the control register is 1, and is unchanged when it is 0.
- R7: At pointer 0x7FF an auto-increment leaves the pointer at 0x7FF; it never wraps to 0x000.
- R8: At pointer 0x0FF an auto-increment leaves the pointer at 0x0FF. Reaching 0x100 needs a write to a pointer byte.
- R9: Addresses 0x100 to 0x7FF are cursor memory that returns the bytes written to it.
- R10: A data-port access to cursor memory while `pclk_alive` is low drives `ready` low and has no effect. The same access completes in the first cycle `pclk_alive` is high while the strobe is held.
- R11: `pal_restart` is high for one cycle after an accepted write to select 3'b000 or 3'b011 while `pal_busy` is high. It stays low for every other access and whenever `pal_busy` is low.
- R12: `rdata` is registered. It takes the selected value at the clock edge that accepts a read and holds between reads. Selects 3'b000, 3'b001 and 3'b011 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 3 | Register select |
| wr_en | input | 1 | Write strobe; wins over a read strobe in the same cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| pclk_alive | input | 1 | High while the pixel clock runs |
| pal_busy | input | 1 | High while a palette read or write sequence is in progress |
| ready | output | 1 | Low while a cursor access is stretched |
| rdata | output | 8 | Registered read data |
| pal_restart | output | 1 | One-cycle pulse when a palette sequence is restarted |

## Verification
Writes, pointer loads and pointer steps take effect at the clock edge that accepts the strobe. So the bench reads them back in a later access, never in the same cycle. `rdata` and `pal_restart` are due one edge after the accepting edge. The bench drives strobes on the falling edge and samples those outputs on the next falling edge. `ready` depends on inputs in the same cycle, so it is sampled shortly after the inputs change. A stretched access is held for several cycles and then checked through the pointer and the memory contents.

// File: rtl/hidx_pkg.sv
package hidx_pkg;
    localparam int DATA_W = 8;
    localparam int PTR_W  = 11;

    typedef enum logic [2:0] {
        SEL_PAL_WADR = 3'b000,
        SEL_PAL_DATA = 3'b001,
        SEL_MASK     = 3'b010,
        SEL_PAL_RADR = 3'b011,
        SEL_IDX_LO   = 3'b100,
        SEL_IDX_HI   = 3'b101,
        SEL_IDX_DATA = 3'b110,
        SEL_IDX_CTL  = 3'b111
    } sel_e;

    localparam logic [PTR_W-1:0] CUR_BASE  = 11'h100;
    localparam logic [PTR_W-1:0] CTRL_LAST = 11'h0FF;
    localparam logic [PTR_W-1:0] PTR_TOP   = 11'h7FF;

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic              autoinc;
        logic [DATA_W-1:0] rdata;
        logic              pal_restart;
    } port_st_t;
endpackage

// File: rtl/hidx_ptr.sv
module hidx_ptr
    import hidx_pkg::*;
#(
    parameter int AW = PTR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lo_wr,
    input  logic          hi_wr,
    input  logic [DW-1:0] wdata,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    localparam int HI_W = AW - DW;

    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (lo_wr) begin
            ptr_d[DW-1:0] = wdata;
        end else if (hi_wr) begin
            ptr_d[AW-1:DW] = wdata[HI_W-1:0];
        end else if (step && ptr_q != PTR_TOP && ptr_q != CTRL_LAST) begin
            ptr_d = ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/hidx_store.sv
module hidx_store
    import hidx_pkg::*;
#(
    parameter int AW     = PTR_W,
    parameter int DW     = DATA_W,
    parameter int CTRL_N = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int CUR_N   = (1 << AW) - int'(CUR_BASE);
    localparam int CTRL_AW = $clog2(CTRL_N);

    logic [DW-1:0] ctrl_q [CTRL_N];
    logic [DW-1:0] cur_mem [CUR_N];
    logic [AW-1:0] cur_off;
    logic          in_cur, in_ctrl;

    assign in_cur  = addr >= CUR_BASE;
    assign in_ctrl = addr < AW'(CTRL_N);
    assign cur_off = addr - CUR_BASE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CTRL_N; i++) ctrl_q[i] <= '0;
        end else if (we && in_ctrl) begin
            ctrl_q[addr[CTRL_AW-1:0]] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (we && in_cur) cur_mem[cur_off] <= wdata;
    end

    always_comb begin
        if (in_cur)       rdata = cur_mem[cur_off];
        else if (in_ctrl) rdata = ctrl_q[addr[CTRL_AW-1:0]];
        else              rdata = '0;
    end
endmodule

// File: rtl/host_index_port.sv
module host_index_port
    import hidx_pkg::*;
#(
    parameter int CTRL_N = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    input  logic       pclk_alive,
    input  logic       pal_busy,
    output logic       ready,
    output logic [7:0] rdata,
    output logic       pal_restart
);
    port_st_t          st_d, st_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [DATA_W-1:0] store_rdata, mux_rdata;
    logic              is_data, stall, wr_take, rd_take;

    assign is_data = sel == SEL_IDX_DATA;
    assign stall   = is_data && (wr_en || rd_en) && ptr_q >= CUR_BASE && !pclk_alive;
    assign wr_take = wr_en && !stall;
    assign rd_take = rd_en && !wr_en && !stall;

    hidx_ptr #(.AW(PTR_W), .DW(DATA_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .lo_wr (wr_take && sel == SEL_IDX_LO),
        .hi_wr (wr_take && sel == SEL_IDX_HI),
        .wdata (wdata),
        .step  ((wr_take || rd_take) && is_data && st_q.autoinc),
        .ptr   (ptr_q)
    );

    hidx_store #(.AW(PTR_W), .DW(DATA_W), .CTRL_N(CTRL_N)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_take && is_data),
        .addr  (ptr_q),
        .wdata (wdata),
        .rdata (store_rdata)
    );

    always_comb begin
        unique case (sel)
            SEL_MASK:     mux_rdata = st_q.mask;
            SEL_IDX_LO:   mux_rdata = ptr_q[DATA_W-1:0];
            SEL_IDX_HI:   mux_rdata = DATA_W'(ptr_q[PTR_W-1:DATA_W]);
            SEL_IDX_DATA: mux_rdata = store_rdata;
            SEL_IDX_CTL:  mux_rdata = DATA_W'(st_q.autoinc);
            default:      mux_rdata = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        st_d.pal_restart = wr_take && pal_busy &&
                           (sel == SEL_PAL_WADR || sel == SEL_PAL_RADR);
        if (wr_take && sel == SEL_MASK)    st_d.mask    = wdata;
        if (wr_take && sel == SEL_IDX_CTL) st_d.autoinc = wdata[0];
        if (rd_take)                       st_d.rdata   = mux_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mask: 8'hFF, autoinc: 1'b0, rdata: 8'h00, pal_restart: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ready       = !stall;
    assign rdata       = st_q.rdata;
    assign pal_restart = st_q.pal_restart;
endmodule

// File: rtl/hidx_chk.sv
module hidx_chk
    import hidx_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       sel,
    input logic             wr_en,
    input logic             rd_en,
    input logic             ready,
    input logic             pal_busy,
    input logic             pal_restart,
    input logic             autoinc,
    input logic [PTR_W-1:0] ptr
);
    logic ptr_load;
    assign ptr_load = wr_en && (sel == SEL_IDX_LO || sel == SEL_IDX_HI);

    // R7
    top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == PTR_TOP && !ptr_load) |=> ptr == PTR_TOP);

    // R8
    ctrl_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == CTRL_LAST && !ptr_load) |=> ptr == CTRL_LAST);

    // R6
    no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!autoinc && !ptr_load) |=> $stable(ptr));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && !ready) |=> $stable(ptr));

    // R11
    restart_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_restart |-> $past(wr_en && pal_busy &&
                              (sel == SEL_PAL_WADR || sel == SEL_PAL_RADR)));

    // R11
    restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pal_restart |=> !pal_restart || $past(wr_en && pal_busy));
endmodule

bind host_index_port hidx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .ready       (ready),
    .pal_busy    (pal_busy),
    .pal_restart (pal_restart),
    .autoinc     (st_q.autoinc),
    .ptr         (ptr_q)
);

// File: tb/host_index_port_bench.sv
`timescale 1ns/1ps
module host_index_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       pclk_alive = 1'b1, pal_busy = 1'b0;
    logic       ready, pal_restart;
    logic [7:0] rdata;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    localparam logic [2:0] S_WA = 3'b000, S_PD = 3'b001, S_MASK = 3'b010, S_RA = 3'b011,
                           S_LO = 3'b100, S_HI = 3'b101, S_DAT = 3'b110, S_CTL = 3'b111;

    always #2.5 clk = ~clk;

    host_index_port u_host_index_port (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .pclk_alive(pclk_alive), .pal_busy(pal_busy),
        .ready(ready), .rdata(rdata), .pal_restart(pal_restart)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] d);
        @(negedge clk);
        sel = s; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic set_ptr(input logic [10:0] p);
        wr(S_HI, {5'b0, p[10:8]});
        wr(S_LO, p[7:0]);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 rdata", rdata, 8'h00);
        check("R1 pal_restart", pal_restart, 1'b0);
        rd(S_MASK, d); check("R1 mask", d, 8'hFF);
        rd(S_LO, d);   check("R1 ptr lo", d, 8'h00);
        rd(S_HI, d);   check("R1 ptr hi", d, 8'h00);
        rd(S_CTL, d);  check("R1 ctl", d, 8'h00);
    endtask

    task automatic t_direct;
        logic [7:0] d;
        wr(S_MASK, 8'h3C); rd(S_MASK, d); check("R2 mask", d, 8'h3C);
        wr(S_LO, 8'hA5);   rd(S_LO, d);   check("R3 lo", d, 8'hA5);
        wr(S_HI, 8'hFE);   rd(S_HI, d);   check("R3 hi bits", d, 8'h06);
        wr(S_CTL, 8'hFE);  rd(S_CTL, d);  check("R4 ctl bit0 clear", d, 8'h00);
        wr(S_CTL, 8'hFF);  rd(S_CTL, d);  check("R4 ctl bit0 set", d, 8'h01);
        rd(S_PD, d);                       check("R12 palette select reads zero", d, 8'h00);
        @(negedge clk); @(negedge clk);
        check("R12 rdata holds", rdata, 8'h00);
    endtask

    task automatic t_ctrl_space;
        logic [7:0] d;
        wr(S_CTL, 8'h00);
        set_ptr(11'h005);
        wr(S_DAT, 8'h77);
        rd(S_LO, d);  check("R6 no step when disabled", d, 8'h05);
        rd(S_DAT, d); check("R5 ctrl reg read", d, 8'h77);
        set_ptr(11'h040);
        wr(S_DAT, 8'h99);
        rd(S_DAT, d); check("R5 unimplemented reads zero", d, 8'h00);
    endtask

    task automatic t_autoinc;
        logic [7:0] d;
        wr(S_CTL, 8'h01);
        set_ptr(11'h000);
        wr(S_DAT, 8'h10); wr(S_DAT, 8'h11); wr(S_DAT, 8'h12);
        rd(S_LO, d); check("R6 step after writes", d, 8'h03);
        set_ptr(11'h000);
        rd(S_DAT, d); check("R6 seq read 0", d, 8'h10);
        rd(S_DAT, d); check("R6 seq read 1", d, 8'h11);
        rd(S_LO, d);  check("R6 step after reads", d, 8'h02);
    endtask

    task automatic t_bounds;
        logic [7:0] d;
        set_ptr(11'h0FF);
        wr(S_DAT, 8'h01);
        rd(S_LO, d); check("R8 hold at 0x0FF lo", d, 8'hFF);
        rd(S_HI, d); check("R8 hold at 0x0FF hi", d, 8'h00);
        set_ptr(11'h7FF);
        wr(S_DAT, 8'hC3);
        rd(S_LO, d); check("R7 no wrap lo", d, 8'hFF);
        rd(S_HI, d); check("R7 no wrap hi", d, 8'h07);
        rd(S_DAT, d); check("R9 cursor top byte", d, 8'hC3);
    endtask

    task automatic t_cursor;
        logic [7:0] d;
        set_ptr(11'h100);
        wr(S_DAT, 8'h11); wr(S_DAT, 8'h22);
        set_ptr(11'h100);
        rd(S_DAT, d); check("R9 cursor 0x100", d, 8'h11);
        rd(S_DAT, d); check("R9 cursor 0x101", d, 8'h22);
    endtask

    task automatic t_stall;
        logic [7:0] d;
        set_ptr(11'h100);
        @(negedge clk);
        pclk_alive = 1'b0; sel = S_DAT; wdata = 8'h5A; wr_en = 1'b1;
        #1 check("R10 ready low", ready, 1'b0);
        repeat (3) @(negedge clk);
        wr_en = 1'b0;
        rd(S_LO, d); check("R10 no step while stalled", d, 8'h00);
        pclk_alive = 1'b1;
        rd(S_DAT, d); check("R10 no write while stalled", d, 8'h11);
        set_ptr(11'h100);
        @(negedge clk);
        pclk_alive = 1'b0; sel = S_DAT; wdata = 8'h5A; wr_en = 1'b1;
        repeat (2) @(negedge clk);
        pclk_alive = 1'b1;
        #1 check("R10 ready returns", ready, 1'b1);
        @(negedge clk);
        wr_en = 1'b0;
        rd(S_LO, d); check("R10 completes one step", d, 8'h01);
        set_ptr(11'h100);
        rd(S_DAT, d); check("R10 completed write", d, 8'h5A);
    endtask

    task automatic t_palette;
        pal_busy = 1'b1;
        wr(S_WA, 8'h00); check("R11 restart on wadr", pal_restart, 1'b1);
        @(negedge clk);  check("R11 single pulse", pal_restart, 1'b0);
        wr(S_RA, 8'h00); check("R11 restart on radr", pal_restart, 1'b1);
        wr(S_LO, 8'h00); check("R11 index write no restart", pal_restart, 1'b0);
        wr(S_DAT, 8'h00); check("R11 data write no restart", pal_restart, 1'b0);
        wr(S_CTL, 8'h01); check("R11 ctl write no restart", pal_restart, 1'b0);
        pal_busy = 1'b0;
        wr(S_WA, 8'h00); check("R11 idle no restart", pal_restart, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_ctrl_space();
        t_autoinc();
        t_cursor();
        t_bounds();
        t_stall();
        t_palette();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule